// File: doc/BRIEF.md
# Bidirectional Three-Position One-Hot Ring Sequencer

This block is a Moore state machine that walks around a ring of three positions. Each position has its own flip-flop and its own output line, so at any moment exactly one of the three output lines is high and marks the current position. Two control inputs steer the ring. One moves it one position forward on each clock, and the other moves it one position backward. When neither is asserted, the position stays where it is. If both are asserted, forward wins.

The position register is built from three flip-flops, one per state. Each flip-flop's next value is a small sum of products with three terms:

- a hold term, taken from its own bit while both controls are low;
- a forward term, taken from the preceding bit;
- a reverse term, taken from the following bit.

A control module decodes the two inputs into a small struct of strobes. A datapath module holds the one-hot register and evaluates the per-bit equations. A synchronous reset places the ring at its home position. Any register pattern that is not one-hot returns the ring to the home position on the next clock.

Top module: `tri_ring_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the ring is at position 0 after that edge: `ringA`=1, `ringB`=0, `ringC`=0. This holds whatever the values of `fwdIn` and `revIn`.
- R2: When `fwdIn` is 1 at a rising edge (and `rst` is 0), the position advances 0→1→2→0. The value of `revIn` has no effect in this case.
- R3: When `fwdIn` is 0 and `revIn` is 1 at a rising edge, the position moves backward 0→2→1→0.
- R4: When `fwdIn` and `revIn` are both 0 at a rising edge, the position is unchanged.
- R5: The outputs are the state flip-flops themselves. `ringA` is high only at position 0, `ringB` only at position 1 and `ringC` only at position 2. Exactly one output is high in every cycle after reset.
- R6: The outputs change only at rising clock edges. A change on `fwdIn` or `revIn` between edges leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to position 0, active high |
| fwdIn | input | 1 | Step forward one position; has priority over revIn |
| revIn | input | 1 | Step backward one position when fwdIn is low |
| ringA | output | 1 | High at position 0 |
| ringB | output | 1 | High at position 1 |
| ringC | output | 1 | High at position 2 |

## Verification
The embedded assertions check the following on every cycle:

- the one-hot property of the outputs;
- the landing position after reset;
- that each forward, backward or hold cycle produces exactly the rotation its inputs select, relative to the previous state;
- that the control strobes are mutually exclusive.

Two properties can only be shown by the bench's scenarios. The first is that the outputs ignore input changes between edges. The second is that the ring follows a modulo-3 position model across long mixed runs, including every pairing of start position and input combination. The recovery path for non-one-hot patterns cannot be reached from the ports. Its assertion guards it instead.

// File: rtl/tri_ring_pkg.sv
package tri_ring_pkg;

  localparam int unsigned RING_LEN = 3;
  localparam int unsigned POS_W    = $clog2(RING_LEN);

  typedef logic [RING_LEN-1:0] ringVec_t;

  localparam ringVec_t HOME_CODE = ringVec_t'(1);

  typedef struct packed {
    logic holdEn;
    logic fwdEn;
    logic revEn;
    logic recoverEn;
  } ringCtl_t;

endpackage

// File: rtl/tri_ring_ctrl.sv
module tri_ring_ctrl
  import tri_ring_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fwdReq,
  input  logic     revReq,
  input  ringVec_t curState,
  output ringCtl_t ctl
);

  logic stateLegal;

  always_comb begin
    stateLegal    = ($countones(curState) == 1);
    ctl.recoverEn = ~stateLegal;
    ctl.fwdEn     = stateLegal & fwdReq;
    ctl.revEn     = stateLegal & ~fwdReq & revReq;
    ctl.holdEn    = stateLegal & ~fwdReq & ~revReq;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot({ctl.holdEn, ctl.fwdEn, ctl.revEn, ctl.recoverEn})); // R2

  AST_FWD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (fwdReq && revReq && !ctl.recoverEn) |-> (ctl.fwdEn && !ctl.revEn)); // R2

endmodule

// File: rtl/tri_ring_dp.sv
module tri_ring_dp
  import tri_ring_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ringCtl_t ctl,
  output ringVec_t stateQ
);

  ringVec_t stateD;

  genvar gi;
  generate
    for (gi = 0; gi < RING_LEN; gi++) begin : g_bit
      localparam int PRED = (gi + RING_LEN - 1) % RING_LEN;
      localparam int SUCC = (gi + 1) % RING_LEN;
      always_comb begin
        stateD[gi] = (ctl.holdEn & stateQ[gi])
                   | (ctl.fwdEn  & stateQ[PRED])
                   | (ctl.revEn  & stateQ[SUCC])
                   | (ctl.recoverEn & HOME_CODE[gi]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stateQ <= HOME_CODE;
    else     stateQ <= stateD;
  end

  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> (stateQ == HOME_CODE)); // R1

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(stateQ)); // R5

  AST_FWD_ROTATE: assert property (@(posedge clk) disable iff (rst)
    ctl.fwdEn |=> (stateQ == {$past(stateQ[RING_LEN-2:0]), $past(stateQ[RING_LEN-1])})); // R2

  AST_REV_ROTATE: assert property (@(posedge clk) disable iff (rst)
    ctl.revEn |=> (stateQ == {$past(stateQ[0]), $past(stateQ[RING_LEN-1:1])})); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ctl.holdEn |=> $stable(stateQ)); // R4

  AST_RECOVER_HOME: assert property (@(posedge clk) disable iff (rst)
    ctl.recoverEn |=> (stateQ == HOME_CODE)); // R5

endmodule

// File: rtl/tri_ring_fsm.sv
module tri_ring_fsm
  import tri_ring_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fwdIn,
  input  logic revIn,
  output logic ringA,
  output logic ringB,
  output logic ringC
);

  ringCtl_t ctl;
  ringVec_t stateQ;

  tri_ring_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fwdReq   (fwdIn),
    .revReq   (revIn),
    .curState (stateQ),
    .ctl      (ctl)
  );

  tri_ring_dp u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .stateQ (stateQ)
  );

  assign ringA = stateQ[0];
  assign ringB = stateQ[1];
  assign ringC = stateQ[2];

endmodule

// File: tb/sim_tri_ring_fsm.sv
`timescale 1ns/1ps
module sim_tri_ring_fsm;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwdIn = 1'b0;
  logic revIn = 1'b0;
  logic ringA, ringB, ringC;

  int testCount = 0;
  int failCount = 0;
  int modelPos  = 0;
  bit doneFlag  = 1'b0;

  always #2 clk = ~clk;

  tri_ring_fsm u0 (
    .clk(clk), .rst(rst), .fwdIn(fwdIn), .revIn(revIn),
    .ringA(ringA), .ringB(ringB), .ringC(ringC)
  );

  function automatic logic [2:0] expVec(int p);
    return 3'b001 << p;
  endfunction

  task automatic checkPos(string tag);
    logic [2:0] got;
    got = {ringC, ringB, ringA};
    testCount++;
    if (got !== expVec(modelPos)) begin
      failCount++;
      $display("FAIL %s: outputs CBA=%b expected %b", tag, got, expVec(modelPos));
    end
  endtask

  // drive at negedge, one rising edge, sample at next negedge
  task automatic stepOnce(logic f, logic r);
    fwdIn = f;
    revIn = r;
    @(negedge clk);
    if (f)      modelPos = (modelPos + 1) % 3;
    else if (r) modelPos = (modelPos + 2) % 3;
  endtask

  task automatic doReset(logic f, logic r);
    rst = 1'b1; fwdIn = f; revIn = r;
    @(negedge clk);
    rst = 1'b0;
    modelPos = 0;
  endtask

  initial begin
    @(negedge clk);
    doReset(1'b0, 1'b0);
    checkPos("R1 reset state");

    // R6: input change between edges does not move outputs
    fwdIn = 1'b1; revIn = 1'b0;
    #1;
    checkPos("R6 no change before edge");
    revIn = 1'b1;
    #0.5;
    checkPos("R6 no change before edge with both high");
    @(negedge clk);
    modelPos = 1;
    checkPos("R2 edge after mid-cycle change");

    // exhaustive: each start position x each input combination
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        doReset(1'b0, 1'b0);
        for (int k = 0; k < s; k++) stepOnce(1'b1, 1'b0);
        checkPos("R5 start position");
        stepOnce(c[1], c[0]);
        if (c[1])       checkPos("R2 forward step");
        else if (c[0])  checkPos("R3 reverse step");
        else            checkPos("R4 hold");
      end
    end

    // full laps in each direction
    doReset(1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin stepOnce(1'b1, 1'b1); checkPos("R2 forward lap, reverse ignored"); end
    for (int k = 0; k < 6; k++) begin stepOnce(1'b0, 1'b1); checkPos("R3 reverse lap"); end
    for (int k = 0; k < 4; k++) begin stepOnce(1'b0, 1'b0); checkPos("R4 long hold"); end

    // reset priority from each position with every input combination
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        doReset(1'b0, 1'b0);
        for (int k = 0; k < s; k++) stepOnce(1'b1, 1'b0);
        doReset(c[1], c[0]);
        checkPos("R1 reset overrides inputs");
      end
    end

    // random mixed run against modulo-3 model
    for (int k = 0; k < 2000; k++) begin
      logic [1:0] rv;
      rv = 2'($urandom);
      stepOnce(rv[1], rv[0]);
      testCount++;
      if ((ringA + ringB + ringC) != 1) begin
        failCount++;
        $display("FAIL R5 onehot: CBA=%b expected exactly one high", {ringC, ringB, ringA});
      end
      checkPos("R2/R3/R4 random run");
    end

    doneFlag = 1'b1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (100000) @(posedge clk);
        testCount++;
        failCount++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule